// File: doc/BRIEF.md
# PCI Function Configuration Register File

This block holds the 256-byte configuration space of one PCI function. Software reaches it through a byte-wide port that carries a function number, a register offset, write data and separate read and write strobes. The block answers only for its own function number. It returns all ones for function numbers beyond the implemented range. Each writable byte keeps only the bits of its write mask. The error flags in the status high byte are sticky: a hardware event pulse sets them, and a write of 1 clears them.

A 16-bit I/O base register and the command register's I/O enable bit together define a 32-byte I/O window. The block presents that window as an aligned base address and a decode-enable flag for the logic behind it. The identity bytes (vendor, device, revision, class code, header type), the interrupt pin and the reset contents of a small window of device-specific bytes are all parameters. One RTL module can therefore be placed once for each function of a multi-function device, and the read data of the instances ORed together.

Top module: `cfg_function_space`

## Requirements
- R1: After reset, a read of the own function returns command 0x00 at offset 0x04, status 0x0200 (0x06 reads 0x00, 0x07 reads 0x02), the I/O base 0x0301 (0x20 reads 0x01, 0x21 reads 0x03), io_base is 0x0300 and io_dec_en is 0.
- R2: The identity bytes read their parameter values (default vendor 0x1A2B at 0x00/0x01 low byte first, device 0x3C4D at 0x02/0x03, revision 0x05 at 0x08, class 0x0C0300 at 0x09..0x0B low byte first, header type 0x00 at 0x0E), and writes to them are ignored.
- R3: A write to offset 0x04 stores only the bits set in the command write mask (default 0x97). Bit 0 is the I/O space enable.
- R4: At offset 0x07, writing 1 to any of bits 5..2 clears that flag, writing 0 leaves it, and bits outside 5..2 keep their reset value whatever is written.
- R5: A write to offset 0x20 drops bits 4..0, and bit 0 then reads back as 1. Offset 0x21 is fully writable.
- R6: io_base equals {byte 0x21, byte 0x20 with bits 4..0 zero}. io_dec_en is 1 exactly when command bit 0 is 1 and io_base is non-zero. Both change in the cycle after the write edge that alters them and at no other time.
- R7: With cfg_func greater than the highest implemented function (default 3), a read returns 0xFF and a write changes nothing.
- R8: With cfg_func within range but not the block's own number (default 2), a read returns 0x00 and a write changes nothing.
- R9: Offsets not named in any requirement (for example 0x05, 0x10, 0x30, 0x44, 0xFF) read 0x00 and ignore writes.
- R10: Offset 0x0D keeps only bits 7..4 of a write. Offset 0x3C is fully writable from reset value 0x00. Offset 0x3D reads the interrupt pin parameter (default 0x04) and ignores writes.
- R11: The device-specific bytes at 0x40..0x43 reset to 0x10, 0x00, 0x5A, 0x20 and keep written bits under masks 0xFF, 0x0F, 0x00, 0xFF respectively.
- R12: cfg_rvalid is 1 in the cycle after a cycle with cfg_rd set, and cfg_rdata then carries the value from before any write in that same cycle. When cfg_rvalid is 0, cfg_rdata is 0x00.
- R13: A 1 on err_evt[i] sets status flag bit i+2 at offset 0x07. When a set and a write-1 clear of the same bit fall in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Register offset of the access |
| cfg_wdata | input | 8 | Write data byte |
| cfg_wr | input | 1 | Write strobe, one cycle per byte |
| cfg_rd | input | 1 | Read strobe, one cycle per byte |
| err_evt | input | 4 | Event pulses that set status flags 5..2 |
| cfg_rdata | output | 8 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| io_dec_en | output | 1 | Enable for decoding the I/O window |
| io_base | output | 16 | Aligned base address of the 32-byte I/O window |

## Verification
Two collisions in the same cycle matter here. In the first, a hardware event sets a status flag while a software write-1 clears that flag. The bench raises err_evt together with a write to 0x07 that clears both the flag being set and a second flag. A later read must show only the second flag cleared. In the second, a read and a write strike the same offset in one cycle. The scoreboard expects the old byte from that read and the new byte from the read that follows.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    // Header offsets that carry behaviour
    localparam logic [7:0] OFS_VID_LO  = 8'h00;
    localparam logic [7:0] OFS_VID_HI  = 8'h01;
    localparam logic [7:0] OFS_DID_LO  = 8'h02;
    localparam logic [7:0] OFS_DID_HI  = 8'h03;
    localparam logic [7:0] OFS_CMD     = 8'h04;
    localparam logic [7:0] OFS_STS_LO  = 8'h06;
    localparam logic [7:0] OFS_STS_HI  = 8'h07;
    localparam logic [7:0] OFS_REV     = 8'h08;
    localparam logic [7:0] OFS_CLS_0   = 8'h09;
    localparam logic [7:0] OFS_CLS_1   = 8'h0A;
    localparam logic [7:0] OFS_CLS_2   = 8'h0B;
    localparam logic [7:0] OFS_LAT     = 8'h0D;
    localparam logic [7:0] OFS_HDR     = 8'h0E;
    localparam logic [7:0] OFS_BASE_LO = 8'h20;
    localparam logic [7:0] OFS_BASE_HI = 8'h21;
    localparam logic [7:0] OFS_IRQ_LN  = 8'h3C;
    localparam logic [7:0] OFS_IRQ_PIN = 8'h3D;

    // Sticky status flags live in bits [STS_EVT_LSB +: STS_EVT_W] of 0x07
    localparam int STS_EVT_LSB = 2;
    localparam int STS_EVT_W   = 4;

    typedef enum logic [1:0] {
        TGT_OTHER  = 2'd0,
        TGT_SELF   = 2'd1,
        TGT_ABSENT = 2'd2
    } tgt_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } cfg_wr_t;

    // Sticky flags: clear-by-one first, then events, so a set always wins
    function automatic logic [STS_EVT_W-1:0] sticky_next(
        input logic [STS_EVT_W-1:0] cur,
        input logic [STS_EVT_W-1:0] clr,
        input logic [STS_EVT_W-1:0] set
    );
        return (cur & ~clr) | set;
    endfunction

    // Keep the bits at and above the window alignment
    function automatic logic [7:0] align_keep(input int win_bits);
        return 8'hFF << win_bits;
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfgsp_pkg::*;
#(
    parameter int FUNC_W   = 3,
    parameter int MAX_FUNC = 3,
    parameter int OWN_FUNC = 2
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    output tgt_e              tgt,
    output cfg_wr_t           wbus
);
    localparam logic [FUNC_W-1:0] MAX_F = FUNC_W'(MAX_FUNC);
    localparam logic [FUNC_W-1:0] OWN_F = FUNC_W'(OWN_FUNC);

    always_comb begin
        if (func > MAX_F)       tgt = TGT_ABSENT;
        else if (func == OWN_F) tgt = TGT_SELF;
        else                    tgt = TGT_OTHER;
    end

    always_comb begin
        wbus.en   = wr && (tgt == TGT_SELF);
        wbus.addr = addr;
        wbus.data = wdata;
    end
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID    = 16'h3C4D,
    parameter logic [7:0]  REV_ID       = 8'h05,
    parameter logic [23:0] CLASS_CODE   = 24'h0C0300,
    parameter logic [7:0]  HDR_TYPE     = 8'h00,
    parameter logic [7:0]  CMD_WMASK    = 8'h97,
    parameter logic [7:0]  LAT_WMASK    = 8'hF0,
    parameter logic [15:0] STATUS_RESET = 16'h0200,
    parameter logic [15:0] BASE_RESET   = 16'h0301,
    parameter logic [7:0]  INT_PIN      = 8'h04,
    parameter int          WIN_BITS     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cfg_wr_t              wbus,
    input  logic [STS_EVT_W-1:0] err_evt,
    input  logic [7:0]           rd_addr,
    output logic [7:0]           rd_data,
    output logic                 io_en,
    output logic [15:0]          base_raw
);
    localparam logic [7:0] LO_KEEP = align_keep(WIN_BITS);
    localparam logic [7:0] STS_HI_FIXED =
        STATUS_RESET[15:8] & ~(8'((1 << STS_EVT_W) - 1) << STS_EVT_LSB);

    logic [7:0]           cmd_q;
    logic [7:0]           lat_q;
    logic [7:0]           base_lo_q;
    logic [7:0]           base_hi_q;
    logic [7:0]           irq_ln_q;
    logic [STS_EVT_W-1:0] sts_q;
    logic [STS_EVT_W-1:0] sts_clr;

    always_comb begin
        sts_clr = '0;
        if (wbus.en && wbus.addr == OFS_STS_HI)
            sts_clr = wbus.data[STS_EVT_LSB +: STS_EVT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= 8'h00;
            lat_q     <= 8'h00;
            base_lo_q <= BASE_RESET[7:0] & LO_KEEP;
            base_hi_q <= BASE_RESET[15:8];
            irq_ln_q  <= 8'h00;
            sts_q     <= STATUS_RESET[8 + STS_EVT_LSB +: STS_EVT_W];
        end else begin
            sts_q <= sticky_next(sts_q, sts_clr, err_evt);
            if (wbus.en) begin
                case (wbus.addr)
                    OFS_CMD:     cmd_q     <= wbus.data & CMD_WMASK;
                    OFS_LAT:     lat_q     <= wbus.data & LAT_WMASK;
                    OFS_BASE_LO: base_lo_q <= wbus.data & LO_KEEP;
                    OFS_BASE_HI: base_hi_q <= wbus.data;
                    OFS_IRQ_LN:  irq_ln_q  <= wbus.data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_VID_LO:  rd_data = VENDOR_ID[7:0];
            OFS_VID_HI:  rd_data = VENDOR_ID[15:8];
            OFS_DID_LO:  rd_data = DEVICE_ID[7:0];
            OFS_DID_HI:  rd_data = DEVICE_ID[15:8];
            OFS_CMD:     rd_data = cmd_q;
            OFS_STS_LO:  rd_data = STATUS_RESET[7:0];
            OFS_STS_HI:  rd_data = STS_HI_FIXED |
                                   (8'(sts_q) << STS_EVT_LSB);
            OFS_REV:     rd_data = REV_ID;
            OFS_CLS_0:   rd_data = CLASS_CODE[7:0];
            OFS_CLS_1:   rd_data = CLASS_CODE[15:8];
            OFS_CLS_2:   rd_data = CLASS_CODE[23:16];
            OFS_LAT:     rd_data = lat_q;
            OFS_HDR:     rd_data = HDR_TYPE;
            OFS_BASE_LO: rd_data = base_lo_q | 8'h01;
            OFS_BASE_HI: rd_data = base_hi_q;
            OFS_IRQ_LN:  rd_data = irq_ln_q;
            OFS_IRQ_PIN: rd_data = INT_PIN;
            default:     rd_data = 8'h00;
        endcase
    end

    assign io_en    = cmd_q[0];
    assign base_raw = {base_hi_q, base_lo_q};
endmodule

// File: rtl/cfg_dev_regs.sv
module cfg_dev_regs
    import cfgsp_pkg::*;
#(
    parameter int                    DEV_BASE  = 8'h40,
    parameter int                    DEV_REGS  = 4,
    parameter logic [DEV_REGS*8-1:0] DEV_WMASK = 32'hFF00_0FFF,
    parameter logic [DEV_REGS*8-1:0] DEV_RESET = 32'h205A_0010
) (
    input  logic       clk,
    input  logic       rst,
    input  cfg_wr_t    wbus,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);
    logic [7:0] byte_q [DEV_REGS];

    for (genvar g = 0; g < DEV_REGS; g++) begin : g_byte
        localparam logic [7:0] OFS  = 8'(DEV_BASE + g);
        localparam logic [7:0] MASK = DEV_WMASK[g*8 +: 8];
        always_ff @(posedge clk) begin
            if (rst)
                byte_q[g] <= DEV_RESET[g*8 +: 8];
            else if (wbus.en && wbus.addr == OFS)
                byte_q[g] <= (byte_q[g] & ~MASK) | (wbus.data & MASK);
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < DEV_REGS; i++)
            if (rd_addr == 8'(DEV_BASE + i))
                rd_data = byte_q[i];
    end
endmodule

// File: rtl/cfg_iowin.sv
module cfg_iowin #(
    parameter int WIN_BITS = 5
) (
    input  logic        io_en,
    input  logic [15:0] base_raw,
    output logic        dec_en,
    output logic [15:0] base
);
    localparam logic [15:0] ALIGN = 16'hFFFF << WIN_BITS;

    always_comb begin
        base   = base_raw & ALIGN;
        dec_en = io_en && (base != 16'h0000);
    end
endmodule

// File: rtl/cfg_function_space.sv
module cfg_function_space
    import cfgsp_pkg::*;
#(
    parameter int                    FUNC_W       = 3,
    parameter int                    MAX_FUNC     = 3,
    parameter int                    OWN_FUNC     = 2,
    parameter logic [15:0]           VENDOR_ID    = 16'h1A2B,
    parameter logic [15:0]           DEVICE_ID    = 16'h3C4D,
    parameter logic [7:0]            REV_ID       = 8'h05,
    parameter logic [23:0]           CLASS_CODE   = 24'h0C0300,
    parameter logic [7:0]            HDR_TYPE     = 8'h00,
    parameter logic [7:0]            CMD_WMASK    = 8'h97,
    parameter logic [7:0]            LAT_WMASK    = 8'hF0,
    parameter logic [15:0]           STATUS_RESET = 16'h0200,
    parameter logic [15:0]           BASE_RESET   = 16'h0301,
    parameter logic [7:0]            INT_PIN      = 8'h04,
    parameter int                    WIN_BYTES    = 32,
    parameter int                    DEV_BASE     = 8'h40,
    parameter int                    DEV_REGS     = 4,
    parameter logic [DEV_REGS*8-1:0] DEV_WMASK    = 32'hFF00_0FFF,
    parameter logic [DEV_REGS*8-1:0] DEV_RESET    = 32'h205A_0010
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [FUNC_W-1:0]    cfg_func,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [STS_EVT_W-1:0] err_evt,
    output logic [7:0]           cfg_rdata,
    output logic                 cfg_rvalid,
    output logic                 io_dec_en,
    output logic [15:0]          io_base
);
    localparam int WIN_BITS = $clog2(WIN_BYTES);

    tgt_e        tgt;
    cfg_wr_t     wbus;
    logic [7:0]  hdr_rd;
    logic [7:0]  dev_rd;
    logic        io_en;
    logic [15:0] base_raw;

    cfg_port_decode #(
        .FUNC_W(FUNC_W), .MAX_FUNC(MAX_FUNC), .OWN_FUNC(OWN_FUNC)
    ) u_dec (
        .func(cfg_func), .addr(cfg_addr), .wdata(cfg_wdata), .wr(cfg_wr),
        .tgt(tgt), .wbus(wbus)
    );

    cfg_hdr_regs #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
        .CLASS_CODE(CLASS_CODE), .HDR_TYPE(HDR_TYPE), .CMD_WMASK(CMD_WMASK),
        .LAT_WMASK(LAT_WMASK), .STATUS_RESET(STATUS_RESET),
        .BASE_RESET(BASE_RESET), .INT_PIN(INT_PIN), .WIN_BITS(WIN_BITS)
    ) u_hdr (
        .clk(clk), .rst(rst), .wbus(wbus), .err_evt(err_evt),
        .rd_addr(cfg_addr), .rd_data(hdr_rd),
        .io_en(io_en), .base_raw(base_raw)
    );

    cfg_dev_regs #(
        .DEV_BASE(DEV_BASE), .DEV_REGS(DEV_REGS),
        .DEV_WMASK(DEV_WMASK), .DEV_RESET(DEV_RESET)
    ) u_devr (
        .clk(clk), .rst(rst), .wbus(wbus),
        .rd_addr(cfg_addr), .rd_data(dev_rd)
    );

    cfg_iowin #(.WIN_BITS(WIN_BITS)) u_win (
        .io_en(io_en), .base_raw(base_raw),
        .dec_en(io_dec_en), .base(io_base)
    );

    // Registered read return; header and device bytes never overlap
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= 8'h00;
        end else begin
            cfg_rvalid <= cfg_rd;
            if (!cfg_rd)
                cfg_rdata <= 8'h00;
            else begin
                case (tgt)
                    TGT_ABSENT: cfg_rdata <= 8'hFF;
                    TGT_SELF:   cfg_rdata <= hdr_rd | dev_rd;
                    default:    cfg_rdata <= 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_function_space_chk.sv
module cfg_function_space_chk #(
    parameter int FUNC_W   = 3,
    parameter int MAX_FUNC = 3,
    parameter int OWN_FUNC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [FUNC_W-1:0] cfg_func,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [7:0]        cfg_rdata,
    input logic              cfg_rvalid,
    input logic              io_dec_en,
    input logic [15:0]       io_base
);
    localparam logic [FUNC_W-1:0] MAX_F = FUNC_W'(MAX_FUNC);
    localparam logic [FUNC_W-1:0] OWN_F = FUNC_W'(OWN_FUNC);

    a_r7_absent_reads_ones: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rd && cfg_func > MAX_F) |-> (cfg_rvalid && cfg_rdata == 8'hFF));

    a_r12_read_follows: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rd) |-> cfg_rvalid);

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_rd) |-> (!cfg_rvalid && cfg_rdata == 8'h00));

    a_r6_dec_needs_base: assert property (@(posedge clk) disable iff (rst)
        io_dec_en |-> (io_base != 16'h0000));

    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_wr) |-> ($stable(io_base) && $stable(io_dec_en)));

    a_r8_foreign_write_inert: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr && cfg_func != OWN_F) |-> ($stable(io_base) && $stable(io_dec_en)));

    a_r5_high_base_written: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr && cfg_func == OWN_F && cfg_addr == 8'h21)
            |-> (io_base[15:8] == $past(cfg_wdata)));

    a_r5_flag_bit_reads_one: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rd && cfg_func == OWN_F && cfg_addr == 8'h20) |-> cfg_rdata[0]);
endmodule

bind cfg_function_space cfg_function_space_chk #(
    .FUNC_W(FUNC_W), .MAX_FUNC(MAX_FUNC), .OWN_FUNC(OWN_FUNC)
) u_chk (
    .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .io_dec_en(io_dec_en), .io_base(io_base)
);

// File: tb/cfg_function_space_tb.sv
module cfg_function_space_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [3:0]  err_evt = '0;
    logic [7:0]  cfg_rdata;
    logic        cfg_rvalid;
    logic        io_dec_en;
    logic [15:0] io_base;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    cfg_function_space u_dut (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .err_evt(err_evt), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .io_dec_en(io_dec_en), .io_base(io_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected byte per returned read
    always @(negedge clk) begin
        if (!rst && cfg_rvalid) begin
            if (exp_q.size() == 0)
                check("R12 rvalid without a pending read", 1, 0);
            else begin
                string t;
                logic [7:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                check(t, {24'h0, cfg_rdata}, {24'h0, e});
            end
        end
    end

    task automatic cfg_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] f, input logic [7:0] a,
                            input logic [7:0] e, input string tag);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic cfg_rw(input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] e_old, input string tag);
        @(negedge clk);
        cfg_func = 3'd2; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1; cfg_rd = 1'b1;
        exp_q.push_back(e_old); tag_q.push_back(tag);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
    endtask

    task automatic evt_pulse(input logic [3:0] v, input logic do_wr, input logic [7:0] d);
        @(negedge clk);
        err_evt = v;
        cfg_func = 3'd2; cfg_addr = 8'h07; cfg_wdata = d; cfg_wr = do_wr;
        @(negedge clk);
        err_evt = 4'h0; cfg_wr = 1'b0;
    endtask

    task automatic io_check(input string tag, input logic en, input logic [15:0] b);
        check({tag, " io_dec_en"}, {31'h0, io_dec_en}, {31'h0, en});
        check({tag, " io_base"}, {16'h0, io_base}, {16'h0, b});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R12 idle rvalid", {31'h0, cfg_rvalid}, 0);
        check("R12 idle rdata", {24'h0, cfg_rdata}, 0);
        io_check("R1 reset", 1'b0, 16'h0300);
        cfg_read(2, 8'h04, 8'h00, "R1 command");
        cfg_read(2, 8'h06, 8'h00, "R1 status low");
        cfg_read(2, 8'h07, 8'h02, "R1 status high");
        cfg_read(2, 8'h20, 8'h01, "R1 base low");
        cfg_read(2, 8'h21, 8'h03, "R1 base high");
        // R2 identity
        cfg_read(2, 8'h00, 8'h2B, "R2 vendor lo");
        cfg_read(2, 8'h01, 8'h1A, "R2 vendor hi");
        cfg_read(2, 8'h02, 8'h4D, "R2 device lo");
        cfg_read(2, 8'h03, 8'h3C, "R2 device hi");
        cfg_read(2, 8'h08, 8'h05, "R2 revision");
        cfg_read(2, 8'h09, 8'h00, "R2 class 0");
        cfg_read(2, 8'h0A, 8'h03, "R2 class 1");
        cfg_read(2, 8'h0B, 8'h0C, "R2 class 2");
        cfg_read(2, 8'h0E, 8'h00, "R2 header type");
        // R11 device bytes reset
        cfg_read(2, 8'h40, 8'h10, "R11 dev0 reset");
        cfg_read(2, 8'h41, 8'h00, "R11 dev1 reset");
        cfg_read(2, 8'h42, 8'h5A, "R11 dev2 reset");
        cfg_read(2, 8'h43, 8'h20, "R11 dev3 reset");

        // R2 writes ignored
        cfg_write(2, 8'h00, 8'hFF);
        cfg_write(2, 8'h03, 8'hFF);
        cfg_write(2, 8'h08, 8'hFF);
        cfg_write(2, 8'h0B, 8'hFF);
        cfg_write(2, 8'h0E, 8'hFF);
        cfg_read(2, 8'h00, 8'h2B, "R2 vendor after write");
        cfg_read(2, 8'h03, 8'h3C, "R2 device after write");
        cfg_read(2, 8'h08, 8'h05, "R2 revision after write");
        cfg_read(2, 8'h0B, 8'h0C, "R2 class after write");
        cfg_read(2, 8'h0E, 8'h00, "R2 header after write");

        // R3 command mask, R6 decode
        cfg_write(2, 8'h04, 8'hFF);
        io_check("R6 enable with base 0300", 1'b1, 16'h0300);
        cfg_read(2, 8'h04, 8'h97, "R3 command mask");

        // R5 base register, R6 window
        cfg_write(2, 8'h20, 8'hFF);
        io_check("R6 base low E0", 1'b1, 16'h03E0);
        cfg_read(2, 8'h20, 8'hE1, "R5 base low fold");
        cfg_write(2, 8'h21, 8'h00);
        io_check("R6 base high cleared", 1'b1, 16'h00E0);
        cfg_write(2, 8'h20, 8'h00);
        io_check("R6 zero base blocks decode", 1'b0, 16'h0000);
        cfg_read(2, 8'h20, 8'h01, "R5 flag bit at zero base");
        cfg_write(2, 8'h20, 8'h3F);
        io_check("R6 base 0020", 1'b1, 16'h0020);
        cfg_write(2, 8'h04, 8'h96);
        io_check("R6 io enable off", 1'b0, 16'h0020);
        cfg_read(2, 8'h04, 8'h96, "R3 command 96");
        cfg_write(2, 8'h04, 8'h01);
        io_check("R6 io enable on", 1'b1, 16'h0020);
        cfg_write(2, 8'h21, 8'hA5);
        cfg_read(2, 8'h21, 8'hA5, "R5 base high writable");
        io_check("R6 base A520", 1'b1, 16'hA520);
        cfg_write(2, 8'h21, 8'h00);

        // R4 / R13 sticky status
        evt_pulse(4'hF, 1'b0, 8'h00);
        cfg_read(2, 8'h07, 8'h3E, "R13 events set flags");
        cfg_write(2, 8'h07, 8'h14);
        cfg_read(2, 8'h07, 8'h2A, "R4 write one clears");
        cfg_write(2, 8'h07, 8'hC3);
        cfg_read(2, 8'h07, 8'h2A, "R4 other bits unaffected");
        evt_pulse(4'h1, 1'b1, 8'h24);
        cfg_read(2, 8'h07, 8'h0E, "R13 set wins over clear");
        cfg_write(2, 8'h07, 8'h3C);
        cfg_read(2, 8'h07, 8'h02, "R4 clear all flags");

        // R7 absent functions
        cfg_read(4, 8'h00, 8'hFF, "R7 absent func 4");
        cfg_read(7, 8'h21, 8'hFF, "R7 absent func 7");
        cfg_write(5, 8'h21, 8'h55);
        cfg_write(6, 8'h04, 8'h00);
        io_check("R7 absent writes inert", 1'b1, 16'h0020);
        cfg_read(2, 8'h21, 8'h00, "R7 own base unchanged");

        // R8 sibling functions
        cfg_read(0, 8'h00, 8'h00, "R8 sibling func 0");
        cfg_read(3, 8'h07, 8'h00, "R8 sibling func 3");
        cfg_write(0, 8'h04, 8'h00);
        cfg_write(1, 8'h20, 8'hC0);
        io_check("R8 sibling writes inert", 1'b1, 16'h0020);
        cfg_read(2, 8'h04, 8'h01, "R8 own command unchanged");

        // R9 unlisted offsets
        cfg_write(2, 8'h05, 8'hFF);
        cfg_write(2, 8'h10, 8'hAA);
        cfg_write(2, 8'h30, 8'hFF);
        cfg_write(2, 8'h44, 8'h77);
        cfg_write(2, 8'hFF, 8'h12);
        cfg_read(2, 8'h05, 8'h00, "R9 offset 05");
        cfg_read(2, 8'h10, 8'h00, "R9 offset 10");
        cfg_read(2, 8'h30, 8'h00, "R9 offset 30");
        cfg_read(2, 8'h44, 8'h00, "R9 offset 44");
        cfg_read(2, 8'hFF, 8'h00, "R9 offset FF");

        // R10 misc header bytes
        cfg_write(2, 8'h0D, 8'hFF);
        cfg_read(2, 8'h0D, 8'hF0, "R10 latency mask");
        cfg_read(2, 8'h3C, 8'h00, "R10 irq line reset");
        cfg_write(2, 8'h3C, 8'hA5);
        cfg_read(2, 8'h3C, 8'hA5, "R10 irq line");
        cfg_write(2, 8'h3D, 8'h00);
        cfg_read(2, 8'h3D, 8'h04, "R10 irq pin");

        // R11 device-specific masks
        cfg_write(2, 8'h40, 8'h77);
        cfg_write(2, 8'h41, 8'hFF);
        cfg_write(2, 8'h42, 8'h00);
        cfg_write(2, 8'h43, 8'h01);
        cfg_read(2, 8'h40, 8'h77, "R11 dev0");
        cfg_read(2, 8'h41, 8'h0F, "R11 dev1");
        cfg_read(2, 8'h42, 8'h5A, "R11 dev2");
        cfg_read(2, 8'h43, 8'h01, "R11 dev3");

        // R12 read and write in the same cycle
        cfg_rw(8'h3C, 8'h11, 8'hA5, "R12 same-cycle read old");
        cfg_read(2, 8'h3C, 8'h11, "R12 read after write");
        cfg_rw(8'h41, 8'hF3, 8'h0F, "R12 same-cycle dev old");
        cfg_read(2, 8'h41, 8'h03, "R12 dev after write");

        repeat (3) @(negedge clk);
        check("R12 no read left pending", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule